// File: doc/BRIEF.md
# Four-Lane Marker Deskew Buffer

This block takes four decoded receive lanes that share one recovered clock and removes the lane-to-lane skew between them. Each lane presents a decoded byte, a control flag and a valid strobe. The skew comes from the medium and from clock recovery that runs separately on each lane. The transmitter places an alignment marker on all four lanes in the same code-group slot during the gap between packets. The marker is the control code group with byte value 0x7C (K28.3). Each lane buffers its stream in a small FIFO, starting with that lane's own marker. Once every lane holds its marker, all four FIFOs are read in lockstep. The outputs then carry symbols that were sent together.

The block has two states. While it searches, a lane drops all input until it sees its marker. The lanes must all report their markers within a bounded window of four code-group times, or the search starts over. Once aligned, every marker that is read out is checked. It must show up on all four lanes in the same read cycle. A marker on only some lanes counts as loss of alignment: the block flushes all four FIFOs and returns to searching.

Top module: `lane_deskew4`

## Requirements
- R1: With rst_ni low, all FIFOs empty, the per-lane marker flags clear, and align_status_o and out_valid_o go low. After release, a stream with no marker produces no output.
- R2: A marker is a symbol with lane valid high, control flag 1 and byte 0x7C. The byte 0x7C with control flag 0 is ordinary data and does not start alignment.
- R3: While searching, each lane discards every symbol before its first marker. The first aligned output word therefore shows the marker (byte 0x7C, control 1) on all four lanes.
- R4: Markers that arrive no more than 4 cycles after the first lane's marker are aligned. Each later output word carries, on every lane, the symbol sent in the same position after that lane's marker, with no symbol lost or repeated.
- R5: Suppose a lane has its marker and SKEW_MAX (4) cycles have passed with at least one lane still missing its marker. The block then flushes all FIFOs and clears all marker flags. A spread of 5 or more cycles never reaches alignment.
- R6: out_valid_o is low until the synchronized read starts, and it is never high without align_status_o. Both signals rise together, in the second clock cycle after the cycle in which the last lane's marker is presented. While out_valid_o is low, the data and control outputs are zero.
- R7: After alignment, a marker that reaches the heads of all four FIFOs in the same read cycle is passed through as one output word, and align_status_o stays high.
- R8: After alignment, a read cycle with the marker at some lane heads but not all of them does the following. That cycle has out_valid_o low. align_status_o drops on the next cycle. The FIFOs are flushed and the search starts again. A later marker on all lanes aligns the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared recovered clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | NUM_LANES*DATA_W | Decoded byte per lane, lane 0 in the low bits |
| lane_ctrl_i | input | NUM_LANES | Control-character flag per lane |
| lane_valid_i | input | NUM_LANES | Symbol strobe per lane |
| out_data_o | output | NUM_LANES*DATA_W | Aligned bytes, lane 0 in the low bits |
| out_ctrl_o | output | NUM_LANES | Aligned control flags |
| out_valid_o | output | 1 | Aligned word is present this cycle |
| align_status_o | output | 1 | Lanes are aligned |

## Verification
The bench sweeps lane skew patterns across the edge of the window. At a spread of exactly 4 the block must align. At a spread of 5 it must not, so an off-by-one timeout would either reject a legal spread or accept an illegal one. Leading idle symbols on the late lanes expose a lane that does not discard its pre-marker input, because the first output would then not be a marker. A 0x7C data byte with control 0 exposes a marker detector that ignores the control flag. A marker on only three lanes after alignment must drop the status and leave the block quiet; a block that passes that word on, or keeps the status high, would be caught. The bench also checks that a mid-stream reset leaves no stale FIFO contents behind.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam logic [7:0] MARKER_BYTE = 8'h7C;

  typedef enum logic {
    ST_SEARCH,
    ST_ALIGNED
  } align_st_e;
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_wr   = wr_i && !full_o && !flush_i;
  assign do_rd   = rd_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= bump(wptr_q);
      if (do_rd) rptr_q <= bump(rptr_q);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/deskew_align_ctrl.sv
module deskew_align_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SKEW_MAX  = 4,
  localparam int TW       = $clog2(SKEW_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] mark_in_i,
  input  logic [NUM_LANES-1:0] head_mark_i,
  input  logic [NUM_LANES-1:0] nonempty_i,
  output logic [NUM_LANES-1:0] seen_o,
  output logic                 aligned_o,
  output logic                 flush_o,
  output logic                 pop_o,
  output logic [TW-1:0]        timer_o
);
  align_st_e            st_q;
  logic [NUM_LANES-1:0] seen_q;
  logic [TW-1:0]        timer_q;
  logic                 all_ne, partial_seen, mismatch, timeout;

  assign all_ne       = &nonempty_i;
  assign partial_seen = (|seen_q) && !(&seen_q);
  // marker on some heads but not all during a read
  assign mismatch     = (st_q == ST_ALIGNED) && all_ne && (|head_mark_i) && !(&head_mark_i);
  assign timeout      = (st_q == ST_SEARCH) && partial_seen && (timer_q == TW'(SKEW_MAX));

  assign flush_o   = mismatch || timeout;
  assign pop_o     = (st_q == ST_ALIGNED) && all_ne && !mismatch;
  assign aligned_o = (st_q == ST_ALIGNED);
  assign seen_o    = seen_q;
  assign timer_o   = timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SEARCH;
      seen_q  <= '0;
      timer_q <= '0;
    end else if (flush_o) begin
      st_q    <= ST_SEARCH;
      seen_q  <= '0;
      timer_q <= '0;
    end else if (st_q == ST_SEARCH) begin
      seen_q  <= seen_q | mark_in_i;
      timer_q <= partial_seen ? timer_q + 1'b1 : '0;
      if (&seen_q) st_q <= ST_ALIGNED;
    end
  end
endmodule

// File: rtl/lane_deskew4.sv
module lane_deskew4
  import deskew_pkg::*;
#(
  parameter int         NUM_LANES  = 4,
  parameter int         DATA_W     = 8,
  parameter int         FIFO_DEPTH = 8,
  parameter int         SKEW_MAX   = 4,
  parameter logic [7:0] ALIGN_CODE = MARKER_BYTE
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_LANES*DATA_W-1:0]   lane_data_i,
  input  logic [NUM_LANES-1:0]          lane_ctrl_i,
  input  logic [NUM_LANES-1:0]          lane_valid_i,
  output logic [NUM_LANES*DATA_W-1:0]   out_data_o,
  output logic [NUM_LANES-1:0]          out_ctrl_o,
  output logic                          out_valid_o,
  output logic                          align_status_o
);
  localparam int SYM_W = DATA_W + 1;
  localparam int TW    = $clog2(SKEW_MAX + 1);

  logic [NUM_LANES-1:0] mark_in, head_mark, nonempty, seen, wr, full;
  logic                 aligned, flush, pop;
  logic [TW-1:0]        skew_timer;

  deskew_align_ctrl #(
    .NUM_LANES(NUM_LANES),
    .SKEW_MAX (SKEW_MAX)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mark_in_i  (mark_in),
    .head_mark_i(head_mark),
    .nonempty_i (nonempty),
    .seen_o     (seen),
    .aligned_o  (aligned),
    .flush_o    (flush),
    .pop_o      (pop),
    .timer_o    (skew_timer)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [DATA_W-1:0] in_byte, head_byte;
    logic              head_ctrl, empty;
    logic [SYM_W-1:0]  head_sym;

    assign in_byte    = lane_data_i[g*DATA_W +: DATA_W];
    assign mark_in[g] = lane_valid_i[g] && lane_ctrl_i[g] && (in_byte == DATA_W'(ALIGN_CODE));
    // pre-marker symbols are dropped while searching
    assign wr[g]      = lane_valid_i[g] && !flush && (aligned || seen[g] || mark_in[g]);

    deskew_lane_fifo #(
      .W    (SYM_W),
      .DEPTH(FIFO_DEPTH)
    ) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(flush),
      .wr_i   (wr[g]),
      .wdata_i({lane_ctrl_i[g], in_byte}),
      .rd_i   (pop),
      .rdata_o(head_sym),
      .empty_o(empty),
      .full_o (full[g])
    );

    assign head_ctrl    = head_sym[DATA_W];
    assign head_byte    = head_sym[DATA_W-1:0];
    assign nonempty[g]  = !empty;
    assign head_mark[g] = nonempty[g] && head_ctrl && (head_byte == DATA_W'(ALIGN_CODE));
    assign out_data_o[g*DATA_W +: DATA_W] = pop ? head_byte : '0;
    assign out_ctrl_o[g] = pop && head_ctrl;
  end

  assign out_valid_o    = pop;
  assign align_status_o = aligned;
endmodule

// File: rtl/lane_deskew4_chk.sv
module lane_deskew4_chk #(
  parameter int         NUM_LANES  = 4,
  parameter int         DATA_W     = 8,
  parameter int         SKEW_MAX   = 4,
  parameter logic [7:0] ALIGN_CODE = 8'h7C,
  localparam int        TW         = $clog2(SKEW_MAX + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_LANES*DATA_W-1:0] out_data_o,
  input logic [NUM_LANES-1:0]        out_ctrl_o,
  input logic                        out_valid_o,
  input logic                        align_status_o,
  input logic [TW-1:0]               timer_i
);
  logic [NUM_LANES-1:0] out_mark;

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++)
      out_mark[i] = out_ctrl_o[i] && (out_data_o[i*DATA_W +: DATA_W] == DATA_W'(ALIGN_CODE));
  end

  a_r6_valid_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> align_status_o);

  a_r6_rise_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(align_status_o) |-> out_valid_o);

  a_r6_quiet_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_ctrl_o == '0 && out_data_o == '0));

  a_r8_marker_lockstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_mark == '0 || (&out_mark)));

  a_r8_drop_is_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_status_o && !out_valid_o) |=> !out_valid_o);

  a_r5_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_i <= TW'(SKEW_MAX));
endmodule

bind lane_deskew4 lane_deskew4_chk #(
  .NUM_LANES (NUM_LANES),
  .DATA_W    (DATA_W),
  .SKEW_MAX  (SKEW_MAX),
  .ALIGN_CODE(ALIGN_CODE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .out_data_o    (out_data_o),
  .out_ctrl_o    (out_ctrl_o),
  .out_valid_o   (out_valid_o),
  .align_status_o(align_status_o),
  .timer_i       (skew_timer)
);

// File: tb/lane_deskew4_bench.sv
module lane_deskew4_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {skew lane0, lane1, lane2, lane3, expect_aligned}
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 3'd0, 3'd0, 3'd0, 1'b1},
    {3'd0, 3'd1, 3'd2, 3'd3, 1'b1},
    {3'd4, 3'd0, 3'd2, 3'd1, 1'b1},
    {3'd0, 3'd0, 3'd0, 3'd4, 1'b1},
    {3'd0, 3'd5, 3'd0, 3'd0, 1'b0},
    {3'd7, 3'd0, 3'd3, 3'd3, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ld = '0;
  logic [3:0]  lc = '0, lv = '0;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;
  logic        out_valid, align_status;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_deskew4 u_lane_deskew4 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .lane_data_i   (ld),
    .lane_ctrl_i   (lc),
    .lane_valid_i  (lv),
    .out_data_o    (out_data),
    .out_ctrl_o    (out_ctrl),
    .out_valid_o   (out_valid),
    .align_status_o(align_status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input logic [7:0] d, input logic c);
    ld[l*8 +: 8] = d;
    lc[l] = c;
    lv[l] = 1'b1;
  endtask

  task automatic all_lanes(input logic [7:0] d, input logic c);
    for (int l = 0; l < 4; l++) set_lane(l, d, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    lv = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(!align_status && !out_valid, "R1 reset state", {align_status, out_valid}, 0);

    // table of skew patterns: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int sk [4];
      int nout;
      bit got;
      for (int l = 0; l < 4; l++) sk[l] = int'(VEC[v][12 - 3*l -: 3]);
      do_reset();
      nout = 0;
      got = 1'b0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (align_status) got = 1'b1;
        if (out_valid) begin
          if (nout == 0)
            chk(out_data == {4{8'h7C}} && out_ctrl == 4'hF, "R3 first word is marker", out_data, {4{8'h7C}});
          else if (nout == 1)
            chk(out_data == {4{8'h10}} && out_ctrl == 4'h0, "R4 lockstep word 1", out_data, {4{8'h10}});
          else if (nout == 2)
            chk(out_data == {4{8'h11}} && out_ctrl == 4'h0, "R4 lockstep word 2", out_data, {4{8'h11}});
          nout++;
        end
        for (int l = 0; l < 4; l++) begin
          if (k < sk[l])       set_lane(l, 8'hBC, 1'b1);
          else if (k == sk[l]) set_lane(l, 8'h7C, 1'b1);
          else                 set_lane(l, 8'(8'h10 + k - sk[l] - 1), 1'b0);
        end
      end
      chk(got == VEC[v][0], "R5 skew window decision", 32'(got), 32'(VEC[v][0]));
      if (VEC[v][0]) chk(nout >= 3, "R4 output count", nout, 3);
    end

    // R2: 0x7C as data does not align
    do_reset();
    all_lanes(8'h7C, 1'b0);
    repeat (3) @(negedge clk);
    all_lanes(8'h55, 1'b0);
    repeat (3) @(negedge clk);
    chk(!align_status && !out_valid, "R2 data 0x7C ignored", {align_status, out_valid}, 0);

    // R6: latency of the synchronized start
    all_lanes(8'h7C, 1'b1);
    @(negedge clk);
    chk(!align_status && !out_valid, "R6 not yet started", {align_status, out_valid}, 0);
    all_lanes(8'h20, 1'b0);
    @(negedge clk);
    chk(align_status && out_valid && out_data == {4{8'h7C}}, "R6 start cycle", out_data, {4{8'h7C}});
    all_lanes(8'h21, 1'b0);
    @(negedge clk);
    chk(out_valid && out_data == {4{8'h20}}, "R4 word after start", out_data, {4{8'h20}});
    all_lanes(8'h22, 1'b0);

    // R7: marker on all lanes after alignment
    begin
      bit stay = 1'b1;
      bit seen_mark = 1'b0;
      @(negedge clk);
      all_lanes(8'h7C, 1'b1);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!align_status) stay = 1'b0;
        if (out_valid && out_data == {4{8'h7C}} && out_ctrl == 4'hF) seen_mark = 1'b1;
        all_lanes(8'(8'h23 + k), 1'b0);
      end
      chk(stay, "R7 status held", 32'(stay), 1);
      chk(seen_mark, "R7 marker passed", 32'(seen_mark), 1);
    end

    // R8: marker on three lanes only
    begin
      bit fell = 1'b0;
      set_lane(0, 8'h7C, 1'b1);
      set_lane(1, 8'h7C, 1'b1);
      set_lane(2, 8'h7C, 1'b1);
      set_lane(3, 8'h30, 1'b0);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!align_status) fell = 1'b1;
        all_lanes(8'(8'h31 + k), 1'b0);
      end
      chk(fell, "R8 status dropped", 32'(fell), 1);
      chk(!align_status && !out_valid, "R8 search again", {align_status, out_valid}, 0);
      all_lanes(8'h7C, 1'b1);
      @(negedge clk);
      all_lanes(8'h40, 1'b0);
      @(negedge clk);
      chk(align_status && out_valid && out_data == {4{8'h7C}}, "R8 realigned", out_data, {4{8'h7C}});
    end

    // R1: reset in the middle of aligned traffic
    all_lanes(8'h41, 1'b0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!align_status && !out_valid, "R1 async reset", {align_status, out_valid}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    all_lanes(8'h42, 1'b0);
    repeat (3) @(negedge clk);
    chk(!align_status && !out_valid, "R1 fifos emptied", {align_status, out_valid}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule